// File: doc/BRIEF.md
# Cascadable Synchronous BCD Decade Counter

This block is a chain of four-bit decimal digits, each counting 0 through 9 in 8421 code. It is meant for synchronous multi-digit counters. Every digit shares one clock, one active-low reset, one active-low load strobe and one parallel count enable. The trickle enable of each digit comes from the terminal-count flag of the digit below it. Carries therefore propagate combinationally within a single clock, and no stage uses a ripple clock.

Each digit is a small state machine. Its sixteen states are D0 to D9, the legal decimal values, and X10 to X15, the six codes outside the decimal range. A mode decoder chooses one of three transitions on each rising clock edge:
- **LOAD** takes the state from the data nibble.
- **COUNT** takes the fixed successor of the current state.
- **HOLD** keeps the current state.

Reset is handled above these three modes. The parameter `ASYNC_RST` selects whether reset clears the state immediately or on the next clock edge. The legal successors run D0→D1→…→D9→D0. The out-of-range successors are X10→X11, X11→D4, X12→X13, X13→D4, X14→X15 and X15→D2.

Top module: `bcd_chain`

## Requirements
- R1: While counting, each digit steps through 0,1,…,9, and 9 (4'b1001) is followed by 0 (4'b0000).
- R2: When ASYNC_RST=1, a low `rst_n` clears every digit at once, with no clock edge needed.
- R3: When ASYNC_RST=0, a low `rst_n` clears every digit on the next rising edge. This takes priority over both load and count.
- R4: When `rst_n` is high and `load_n` is low, the next rising edge copies `load_data` into `count`, whatever the enable inputs are. Digit k occupies bits [4k+3:4k].
- R5: With `rst_n` and `load_n` high, the chain advances only when both `cnt_en_p` and `cnt_en_t` are high. If either is low, `count` holds.
- R6: A digit's terminal-count flag is its trickle enable ANDed with a full decode of state 9. `tc_out` is high only when `cnt_en_t` is high and every digit reads 9.
- R7: A digit holding a code from 10 to 15 follows 10→11, 11→4, 12→13, 13→4, 14→15 and 15→2 when it counts. It therefore reaches 0–9 within two counting edges.
- R8: Digit k+1 counts only when digit k is at 9 with its trickle enable high. The chain rolls over correctly, for example 0999→1000 and 9999→0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asynchronous or synchronous according to ASYNC_RST |
| load_n | input | 1 | Active-low parallel load strobe |
| load_data | input | 4*NDIG | Digits to load, least significant digit in bits [3:0] |
| cnt_en_p | input | 1 | Parallel count enable, shared by all digits |
| cnt_en_t | input | 1 | Trickle enable of the lowest digit |
| count | output | 4*NDIG | Current digits, least significant digit in bits [3:0] |
| tc_out | output | 1 | Terminal count of the top digit |

## Verification
The assertions assume that the control inputs and `load_data` change only away from the rising clock edge. They also assume that `rst_n` is driven low at the start, so that no state is sampled before the first clear. The bench respects both: it drives every input on the falling edge, and it holds reset low for several cycles before any other stimulus. Its random phase loads arbitrary nibbles, so the six out-of-range codes are entered through the load path, never through power-up.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
    typedef enum logic [3:0] {
        D0  = 4'd0,  D1  = 4'd1,  D2  = 4'd2,  D3  = 4'd3,
        D4  = 4'd4,  D5  = 4'd5,  D6  = 4'd6,  D7  = 4'd7,
        D8  = 4'd8,  D9  = 4'd9,  X10 = 4'd10, X11 = 4'd11,
        X12 = 4'd12, X13 = 4'd13, X14 = 4'd14, X15 = 4'd15
    } dig_e;

    typedef enum logic [1:0] {
        M_HOLD  = 2'd0,
        M_COUNT = 2'd1,
        M_LOAD  = 2'd2
    } mode_e;

    localparam int DIG_W = 4;
endpackage

// File: rtl/bcd_digit_next.sv
module bcd_digit_next
    import bcd_pkg::*;
(
    input  dig_e cur,
    output dig_e succ
);
    // Successor of every code; codes 10..15 reach 0..9 within two steps (R7)
    always_comb begin
        unique case (cur)
            D0:  succ = D1;
            D1:  succ = D2;
            D2:  succ = D3;
            D3:  succ = D4;
            D4:  succ = D5;
            D5:  succ = D6;
            D6:  succ = D7;
            D7:  succ = D8;
            D8:  succ = D9;
            D9:  succ = D0;   // R1 wrap
            X10: succ = X11;
            X11: succ = D4;
            X12: succ = X13;
            X13: succ = D4;
            X14: succ = X15;
            X15: succ = D2;
            default: succ = D0;
        endcase
    end
endmodule

// File: rtl/bcd_digit.sv
module bcd_digit
    import bcd_pkg::*;
#(
    parameter bit ASYNC_RST = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic [DIG_W-1:0] load_val,
    input  logic             en_p,
    input  logic             en_t,
    output logic [DIG_W-1:0] q,
    output logic             tc
);
    dig_e  state_q;
    dig_e  state_d;
    dig_e  succ;
    mode_e mode;

    bcd_digit_next next_i (
        .cur  (state_q),
        .succ (succ)
    );

    // Mode decode: load beats count, count needs both enables (R4, R5)
    always_comb begin
        if (!load_n)
            mode = M_LOAD;
        else if (en_p && en_t)
            mode = M_COUNT;
        else
            mode = M_HOLD;
    end

    always_comb begin
        unique case (mode)
            M_LOAD:  state_d = dig_e'(load_val);
            M_COUNT: state_d = succ;
            M_HOLD:  state_d = state_q;
            default: state_d = state_q;
        endcase
    end

    // State register; reset style picked by parameter (R2, R3)
    generate
        if (ASYNC_RST) begin : g_async
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    state_q <= D0;
                else
                    state_q <= state_d;
            end
        end else begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n)
                    state_q <= D0;
                else
                    state_q <= state_d;
            end
        end
    endgenerate

    // Outputs (R6)
    always_comb begin
        q  = state_q;
        tc = en_t && (state_q == D9);
    end
endmodule

// File: rtl/bcd_chain.sv
module bcd_chain
    import bcd_pkg::*;
#(
    parameter int NDIG      = 4,
    parameter bit ASYNC_RST = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_n,
    input  logic [4*NDIG-1:0]     load_data,
    input  logic                  cnt_en_p,
    input  logic                  cnt_en_t,
    output logic [4*NDIG-1:0]     count,
    output logic                  tc_out
);
    localparam int W = DIG_W * NDIG;

    logic [NDIG:0]   trickle;
    logic [NDIG-1:0] dig_tc;

    assign trickle[0] = cnt_en_t;

    // Each digit's trickle enable is the terminal count of the one below (R8)
    generate
        for (genvar k = 0; k < NDIG; k++) begin : g_dig
            bcd_digit #(.ASYNC_RST(ASYNC_RST)) dig_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .load_n   (load_n),
                .load_val (load_data[k*DIG_W +: DIG_W]),
                .en_p     (cnt_en_p),
                .en_t     (trickle[k]),
                .q        (count[k*DIG_W +: DIG_W]),
                .tc       (dig_tc[k])
            );
            assign trickle[k+1] = dig_tc[k];
        end
    endgenerate

    assign tc_out = trickle[NDIG];

    logic [W-1:0] unused_w;
    assign unused_w = '0;
endmodule

// File: rtl/bcd_chain_chk.sv
module bcd_chain_chk #(
    parameter int NDIG      = 4,
    parameter bit ASYNC_RST = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_n,
    input logic [4*NDIG-1:0] load_data,
    input logic              cnt_en_p,
    input logic              cnt_en_t,
    input logic [4*NDIG-1:0] count,
    input logic              tc_out
);
    localparam logic [4*NDIG-1:0] ALL9 = {NDIG{4'd9}};

    generate
        if (ASYNC_RST) begin : g_a
            a_r2_async_clear: assert property (@(posedge clk)
                !rst_n |-> count == '0);
        end else begin : g_s
            a_r3_sync_clear: assert property (@(posedge clk)
                !rst_n |=> count == '0);
        end
    endgenerate

    a_r4_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> count == $past(load_data));

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !(cnt_en_p && cnt_en_t)) |=> $stable(count));

    a_r6_tc_only_full: assert property (@(posedge clk) disable iff (!rst_n)
        tc_out |-> (cnt_en_t && count == ALL9));

    a_r7_recover: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && cnt_en_p && cnt_en_t && count[0] && count[3:1] >= 3'd5)
        |=> count[3:0] <= 4'd9);
endmodule

bind bcd_chain bcd_chain_chk #(.NDIG(NDIG), .ASYNC_RST(ASYNC_RST)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_n    (load_n),
    .load_data (load_data),
    .cnt_en_p  (cnt_en_p),
    .cnt_en_t  (cnt_en_t),
    .count     (count),
    .tc_out    (tc_out)
);

// File: tb/bcd_chain_tb_top.sv
`timescale 1ns/1ps
module bcd_chain_tb_top;
    localparam int ND = 4;
    localparam int W  = 4*ND;

    logic clk = 1'b0;
    logic rst_n, load_n, cep, cet;
    logic [W-1:0] ldat;
    logic [W-1:0] cnt_a, cnt_s;
    logic tc_a, tc_s;
    int checks = 0;
    int errors = 0;
    logic [W-1:0] model;

    always #4 clk = ~clk;

    bcd_chain #(.NDIG(ND), .ASYNC_RST(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .load_data(ldat),
        .cnt_en_p(cep), .cnt_en_t(cet), .count(cnt_a), .tc_out(tc_a));

    bcd_chain #(.NDIG(ND), .ASYNC_RST(1'b0)) dut_s_i (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .load_data(ldat),
        .cnt_en_p(cep), .cnt_en_t(cet), .count(cnt_s), .tc_out(tc_s));

    // vector: {load_n, data[15:0], cep, cet, exp[15:0], exp_tc}
    localparam int NV = 13;
    localparam logic [35:0] VEC [NV] = '{
        {1'b0, 16'h0998, 1'b1, 1'b1, 16'h0998, 1'b0},
        {1'b1, 16'h0000, 1'b1, 1'b1, 16'h0999, 1'b0},
        {1'b1, 16'h0000, 1'b1, 1'b1, 16'h1000, 1'b0},
        {1'b1, 16'h0000, 1'b0, 1'b1, 16'h1000, 1'b0},
        {1'b1, 16'h0000, 1'b1, 1'b0, 16'h1000, 1'b0},
        {1'b0, 16'h9999, 1'b0, 1'b1, 16'h9999, 1'b1},
        {1'b1, 16'h0000, 1'b1, 1'b1, 16'h0000, 1'b0},
        {1'b0, 16'h0009, 1'b1, 1'b1, 16'h0009, 1'b0},
        {1'b1, 16'h0000, 1'b1, 1'b0, 16'h0009, 1'b0},
        {1'b1, 16'h0000, 1'b1, 1'b1, 16'h0010, 1'b0},
        {1'b0, 16'h000F, 1'b1, 1'b1, 16'h000F, 1'b0},
        {1'b1, 16'h0000, 1'b1, 1'b1, 16'h0002, 1'b0},
        {1'b1, 16'h0000, 1'b1, 1'b1, 16'h0003, 1'b0}
    };

    function automatic logic [3:0] succ(input logic [3:0] d);
        case (d)
            4'd9:  succ = 4'd0;
            4'd10: succ = 4'd11;
            4'd11: succ = 4'd4;
            4'd12: succ = 4'd13;
            4'd13: succ = 4'd4;
            4'd14: succ = 4'd15;
            4'd15: succ = 4'd2;
            default: succ = d + 4'd1;
        endcase
    endfunction

    function automatic logic [W-1:0] model_next(input logic [W-1:0] m,
        input logic r, input logic l, input logic [W-1:0] d,
        input logic p, input logic t);
        logic [W-1:0] n;
        logic tt;
        if (!r) return '0;
        if (!l) return d;
        n = m;
        tt = t;
        for (int k = 0; k < ND; k++) begin
            if (p && tt) n[4*k +: 4] = succ(m[4*k +: 4]);
            tt = tt && (m[4*k +: 4] == 4'd9);
        end
        return n;
    endfunction

    function automatic logic model_tc(input logic [W-1:0] m, input logic t);
        return t && (m == {ND{4'd9}});
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic l, input logic [W-1:0] d,
                        input logic p, input logic t);
        @(negedge clk);
        rst_n = r; load_n = l; ldat = d; cep = p; cet = t;
        model = model_next(model, r, l, d, p, t);
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; load_n = 1'b1; ldat = '0; cep = 1'b0; cet = 1'b0;
        model = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R2 reset state async", cnt_a, '0);
        chk("R3 reset state sync", cnt_s, '0);

        // table walk (R1, R4, R5, R6, R7, R8)
        for (int i = 0; i < NV; i++) begin
            step(1'b1, VEC[i][35], VEC[i][34:19], VEC[i][18], VEC[i][17]);
            chk("R1/R4/R5/R8 table async", cnt_a, VEC[i][16:1]);
            chk("R1/R4/R5/R8 table sync", cnt_s, VEC[i][16:1]);
            chk("R6 tc table", {15'd0, tc_a}, {15'd0, VEC[i][0]});
        end

        // R1 full single-digit sweep
        step(1'b1, 1'b0, 16'h0000, 1'b0, 1'b0);
        for (int i = 1; i <= 10; i++) begin
            step(1'b1, 1'b1, '0, 1'b1, 1'b1);
            chk("R1 sweep", cnt_a, model);
        end
        chk("R1 wrap 9 to 0 carries", cnt_a, 16'h0010);

        // R7 each out-of-range code recovers within two counts
        for (int c = 10; c < 16; c++) begin
            step(1'b1, 1'b0, {12'h000, 4'(c)}, 1'b0, 1'b0);
            step(1'b1, 1'b1, '0, 1'b1, 1'b1);
            chk("R7 first successor", cnt_s, {12'h000, succ(4'(c))});
            step(1'b1, 1'b1, '0, 1'b1, 1'b1);
            checks++;
            if (cnt_a[3:0] > 4'd9 || cnt_a[15:4] != 12'h000) begin
                errors++;
                $display("FAIL R7: actual %h expected legal digit", cnt_a);
            end
        end

        // R2 async clear mid-cycle; R3 sync clear overrides load
        step(1'b1, 1'b0, 16'h4567, 1'b1, 1'b1);
        @(negedge clk);
        rst_n = 1'b0; load_n = 1'b0; ldat = 16'h1234;
        #1;
        chk("R2 immediate clear", cnt_a, '0);
        chk("R3 no clear before edge", cnt_s, 16'h4567);
        @(posedge clk);
        #1;
        chk("R3 clear beats load", cnt_s, '0);
        model = '0;

        // R6 tc needs cnt_en_t
        step(1'b1, 1'b0, 16'h9999, 1'b0, 1'b0);
        chk("R6 tc low without trickle", {15'd0, tc_s}, 16'd0);
        @(negedge clk); cet = 1'b1; #1;
        chk("R6 tc high at 9999", {15'd0, tc_s}, 16'd1);

        // random phase vs model, all 16 codes through loads
        for (int i = 0; i < 3000; i++) begin
            logic r, l, p, t;
            r = ($urandom_range(0, 19) != 0);
            l = ($urandom_range(0, 5) != 0);
            p = ($urandom_range(0, 3) != 0);
            t = ($urandom_range(0, 3) != 0);
            step(r, l, 16'($urandom), p, t);
            chk("R1-model async", cnt_a, model);
            chk("R5-model sync", cnt_s, model);
            chk("R6 tc model", {15'd0, tc_s}, {15'd0, model_tc(model, t)});
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule